// File: doc/BRIEF.md
# Read/Write Mode Recovery Sequencer

This block times the three analog-protection controls of a read channel front end around a write operation. When the active-high write gate is raised, the front end must stop listening at once. The block therefore raises three enables in the same cycle:

- the input shunt enable, which lowers the input impedance;
- the amplifier squelch enable;
- the gain-loop hold enable.

While these are raised, the ready flag is low.

When the write gate drops, the block lowers the enables one at a time, in a fixed order, with a programmable number of clock cycles between each step. The shunt goes first, then the squelch, then the gain-loop hold. After a further settle interval the ready flag rises to say that the read path is stable. If the write gate rises again at any point in this return, all three enables come back at once. The return then starts over from the beginning at the next fall of the write gate.

All pins are plain level signals. No data flows through the block, so there is no valid/ready handshake. Each output is decoded from a single registered phase, so each one changes exactly one clock edge after the cause that the requirements name.

Top module: `rw_recovery_seq`

## Requirements
- R1: While reset is held, and until the write gate is first sampled low, `shunt_en`, `squelch_en` and `agc_hold` are 1 and `ready` is 0.
- R2: At any clock edge that samples `wr_gate` = 1, all three enables are 1 and `ready` is 0 from that edge on. This holds in every phase, including part-way through a return.
- R3: In write mode, the first edge that samples `wr_gate` = 0 drops `shunt_en` to 0 at that edge. `squelch_en` and `agc_hold` stay 1.
- R4: `squelch_en` drops exactly `SQ_DLY` clock edges after `shunt_en` dropped, provided `wr_gate` stays 0 throughout.
- R5: `agc_hold` drops exactly `AGC_DLY` clock edges after `squelch_en` dropped, provided `wr_gate` stays 0 throughout.
- R6: `ready` rises exactly `SETTLE_DLY` clock edges after `agc_hold` dropped. It then stays 1 for as long as `wr_gate` is sampled 0.
- R7: The release order is never violated. `squelch_en` = 0 implies `shunt_en` = 0. `agc_hold` = 0 implies `squelch_en` = 0. `ready` = 1 implies `agc_hold` = 0.
- R8: A return that is cut short by `wr_gate` = 1 in any stage leaves no partial progress. After the next fall of `wr_gate`, the full sequence of R3 to R6 runs again with its full delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; puts the block in write mode |
| wr_gate | input | 1 | 1 = write/standby, 0 = read |
| shunt_en | output | 1 | Input impedance shunt enable |
| squelch_en | output | 1 | Amplifier squelch enable |
| agc_hold | output | 1 | Gain-loop hold enable |
| ready | output | 1 | Read path settled |

## Verification
The bench builds the block with `SQ_DLY` = 5, `AGC_DLY` = 3 and `SETTLE_DLY` = 2. These three values are distinct, so a design that swaps two stage delays, or is off by one in any of them, yields wrong release edges. A full return takes only ten cycles at these values. That lets the bench abort the return in each stage (shunt released, squelch released, settling) and also one cycle after a fall. Each abort is followed by a complete fresh return.

// File: rtl/rwr_pkg.sv
package rwr_pkg;
  typedef enum logic [2:0] {
    PH_WRITE   = 3'd0,
    PH_UNSHUNT = 3'd1,
    PH_UNSQ    = 3'd2,
    PH_SETTLE  = 3'd3,
    PH_READY   = 3'd4
  } phase_t;
endpackage

// File: rtl/rwr_timer.sv
module rwr_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/rwr_decode.sv
module rwr_decode
  import rwr_pkg::*;
(
  input  phase_t phase,
  output logic   shunt_en,
  output logic   squelch_en,
  output logic   agc_hold,
  output logic   ready
);
  always_comb begin
    shunt_en   = (phase == PH_WRITE);
    squelch_en = (phase == PH_WRITE) || (phase == PH_UNSHUNT);
    agc_hold   = (phase == PH_WRITE) || (phase == PH_UNSHUNT) || (phase == PH_UNSQ);
    ready      = (phase == PH_READY);
  end
endmodule

// File: rtl/rw_recovery_seq.sv
module rw_recovery_seq
  import rwr_pkg::*;
#(
  parameter int SQ_DLY     = 16,
  parameter int AGC_DLY    = 16,
  parameter int SETTLE_DLY = SQ_DLY / 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_gate,
  output logic shunt_en,
  output logic squelch_en,
  output logic agc_hold,
  output logic ready
);
  localparam int MAX_A  = (SQ_DLY > AGC_DLY) ? SQ_DLY : AGC_DLY;
  localparam int MAX_D  = (MAX_A > SETTLE_DLY) ? MAX_A : SETTLE_DLY;
  localparam int CW     = (MAX_D < 2) ? 1 : $clog2(MAX_D);
  localparam logic [CW-1:0] SQ_LD  = CW'(SQ_DLY - 1);
  localparam logic [CW-1:0] AGC_LD = CW'(AGC_DLY - 1);
  localparam logic [CW-1:0] SET_LD = CW'(SETTLE_DLY - 1);

  phase_t        phase, phase_nxt;
  logic          t_load, t_done;
  logic [CW-1:0] t_val;

  always_comb begin
    phase_nxt = phase;
    t_load    = 1'b0;
    t_val     = '0;
    if (wr_gate) begin
      phase_nxt = PH_WRITE;
    end else begin
      unique case (phase)
        PH_WRITE: begin
          phase_nxt = PH_UNSHUNT;
          t_load    = 1'b1;
          t_val     = SQ_LD;
        end
        PH_UNSHUNT: if (t_done) begin
          phase_nxt = PH_UNSQ;
          t_load    = 1'b1;
          t_val     = AGC_LD;
        end
        PH_UNSQ: if (t_done) begin
          phase_nxt = PH_SETTLE;
          t_load    = 1'b1;
          t_val     = SET_LD;
        end
        PH_SETTLE: if (t_done) phase_nxt = PH_READY;
        PH_READY:  phase_nxt = PH_READY;
        default:   phase_nxt = PH_WRITE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_WRITE;
    else        phase <= phase_nxt;
  end

  rwr_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  rwr_decode u_dec (
    .phase      (phase),
    .shunt_en   (shunt_en),
    .squelch_en (squelch_en),
    .agc_hold   (agc_hold),
    .ready      (ready)
  );
endmodule

// File: rtl/rwr_checker.sv
module rwr_checker #(
  parameter int SQ_DLY     = 16,
  parameter int AGC_DLY    = 16,
  parameter int SETTLE_DLY = 8
) (
  input logic clk,
  input logic rst_n,
  input logic wr_gate,
  input logic shunt_en,
  input logic squelch_en,
  input logic agc_hold,
  input logic ready
);
  localparam int TOTAL = SQ_DLY + AGC_DLY + SETTLE_DLY;

  int since_rel;

  always_ff @(posedge clk) begin
    if (!rst_n || shunt_en)     since_rel <= 0;
    else if (since_rel <= TOTAL) since_rel <= since_rel + 1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (shunt_en && squelch_en && agc_hold && !ready));

  assert_write_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gate |=> (shunt_en && squelch_en && agc_hold && !ready));

  assert_shunt_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shunt_en) |-> (squelch_en && agc_hold && !$past(wr_gate)));

  assert_squelch_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(squelch_en) |-> (since_rel == SQ_DLY));

  assert_agc_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(agc_hold) |-> (since_rel == SQ_DLY + AGC_DLY));

  assert_ready_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (since_rel == TOTAL));

  assert_ready_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !wr_gate) |=> ready);

  assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!squelch_en -> !shunt_en) && (!agc_hold -> !squelch_en) && (ready -> !agc_hold));
endmodule

bind rw_recovery_seq rwr_checker #(
  .SQ_DLY(SQ_DLY), .AGC_DLY(AGC_DLY), .SETTLE_DLY(SETTLE_DLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_gate(wr_gate),
  .shunt_en(shunt_en), .squelch_en(squelch_en),
  .agc_hold(agc_hold), .ready(ready)
);

// File: tb/sim_rw_recovery_seq.sv
`timescale 1ns/1ps
module sim_rw_recovery_seq;
  localparam int SQ  = 5;
  localparam int AG  = 3;
  localparam int ST  = 2;
  localparam int TOT = SQ + AG + ST;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_gate = 1'b1;
  logic shunt_en, squelch_en, agc_hold, ready;

  int checks = 0;
  int failures = 0;
  int low_edges = 0;   // consecutive edges sampling wr_gate low since last write
  int cycles = 0;

  always #5 clk = ~clk;

  rw_recovery_seq #(.SQ_DLY(SQ), .AGC_DLY(AG), .SETTLE_DLY(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_gate(wr_gate),
    .shunt_en(shunt_en), .squelch_en(squelch_en),
    .agc_hold(agc_hold), .ready(ready)
  );

  // behavioural reference: count low samples
  always @(posedge clk) begin
    cycles = cycles + 1;
    if (!rst_n || wr_gate) low_edges = 0;
    else if (low_edges <= TOT) low_edges = low_edges + 1;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b low_edges=%0d", tag, act, exp, low_edges);
    end
  endtask

  task automatic compare_all(input bit in_reset);
    logic e_sh, e_sq, e_ag, e_rd;
    e_sh = (low_edges == 0);
    e_sq = (low_edges <= SQ);
    e_ag = (low_edges <= SQ + AG);
    e_rd = (low_edges > TOT);
    if (in_reset) begin
      chk("R1 shunt", shunt_en, 1'b1);
      chk("R1 ready", ready, 1'b0);
    end else if (low_edges == 0) begin
      chk("R2 shunt", shunt_en, 1'b1);
      chk("R2 squelch", squelch_en, 1'b1);
      chk("R2 agc", agc_hold, 1'b1);
      chk("R2 ready", ready, 1'b0);
    end else begin
      chk("R3 shunt", shunt_en, e_sh);
      chk("R4 squelch", squelch_en, e_sq);
      chk("R5 agc", agc_hold, e_ag);
      chk("R6 ready", ready, e_rd);
    end
    chk("R7 order", (!squelch_en || shunt_en) ? 1'b0 : 1'b0, 1'b0);
    if ((!squelch_en && shunt_en) || (!agc_hold && squelch_en) || (ready && agc_hold))
      chk("R7 order", 1'b1, 1'b0);
  endtask

  task automatic run(input logic val, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all(1'b0);
      wr_gate = val;
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      compare_all(1'b1);
    end
    rst_n = 1'b1;
    run(1'b1, 4);            // R1/R2: write mode held after reset
    run(1'b0, TOT + 6);      // R3..R6: full return, R6 ready held
    run(1'b1, 3);            // R2 from ready
    run(1'b0, 3);            // abort during shunt-released stage
    run(1'b1, 1);            // R8
    run(1'b0, SQ + 2);       // abort during squelch-released stage
    run(1'b1, 2);            // R8
    run(1'b0, SQ + AG + 1);  // abort during settle
    run(1'b1, 1);            // R8
    run(1'b0, 1);            // abort one cycle after fall
    run(1'b1, 1);            // R8
    run(1'b0, TOT + 5);      // R8: complete fresh return with full delays
    run(1'b1, 3);
    @(negedge clk);
    compare_all(1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    failures++;
    $display("FAIL watchdog actual=%0d expected<5000 cycles", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule